// File: doc/BRIEF.md
# Bus Loan Handshake Controller

This block decides when a processor core gives its external bus to another master. An outside master raises a request. The block passes that request through a synchronizer and then waits for the core to reach an instruction boundary. At the boundary it issues a grant and switches off the core's bus drivers. When the request is withdrawn, the block drops the grant, turns the drivers back on, and the core resumes where it stopped.

The core may need an external access while the bus is on loan. In that case the block raises a separate hang flag and stalls the core. Once the master lets go, the hang flag and the grant clear together, the stall lifts and the pending access goes ahead.

The handshake does not pause for reset. A request that arrives while reset is held is granted at once, because no instruction is running that needs a boundary. A debug-mode select swaps in a second request, reset and grant. While that select is high, the normal grant pin is switched off through its output enable.

Top module: `bus_loan_ctrl`

States and transitions:
- IDLE: no loan.
  - A synchronized request moves the block to WAIT_BOUNDARY.
- WAIT_BOUNDARY: a request is seen and the block is waiting for the core.
  - A boundary strobe moves it to GRANTED.
  - A dropped request moves it back to IDLE.
- GRANTED: the bus is on loan.
  - A pending core access moves it to GRANTED_HANG.
  - A dropped request moves it to IDLE.
- GRANTED_HANG: the bus is on loan and the core is blocked.
  - A withdrawn access moves it back to GRANTED.
  - A dropped request moves it to IDLE.
- Active reset forces the state to GRANTED if the synchronized request is high, and to IDLE if it is low.

## Requirements
- R1: The request passes through two flip-flops before the state machine sees it. If the core boundary strobe is held high, the grant rises after the fourth clock edge following the request's rise, and not earlier.
- R2: Outside reset, the grant is issued only on a clock edge where the synchronized request is high and the core boundary strobe is high, while the block is waiting in WAIT_BOUNDARY.
- R3: The driver enable `drv_en` is 1 exactly when no grant is held, and 0 while the bus is granted (GRANTED or GRANTED_HANG).
- R4: After the request falls, the grant and the hang flag both clear after the third clock edge, and `drv_en` returns to 1 on that same edge.
- R5: The hang flag `grant_hang` rises on the edge after one where the block is in GRANTED with `core_ext_pend` high. It is 1 only in GRANTED_HANG.
- R6: `core_stall` is the combinational AND of `core_ext_pend` and grant-held (the state is GRANTED or GRANTED_HANG).
- R7: While the selected reset is high, the state is IDLE if the synchronized request is 0, and GRANTED if it is 1, without waiting for a boundary. After reset the outputs show no grant, `drv_en`=1 and no hang.
- R8: With `emu_en`=1, the block uses `emu_req` and `emu_rst` in place of `ext_req` and `sys_rst`:
  - the grant appears on `emu_grant`;
  - `bus_grant` is 0 and `bus_grant_oe` is 0.
  - With `emu_en`=0, `emu_grant` is 0 and `bus_grant_oe` is 1.
- R9: In GRANTED_HANG, if `core_ext_pend` is low at a clock edge, the hang flag clears on that edge while the grant stays held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | Normal core reset, active high, synchronous |
| emu_rst | input | 1 | Debug-mode reset, active high |
| emu_en | input | 1 | Selects the debug-mode request/reset/grant set |
| ext_req | input | 1 | Normal bus request, asynchronous |
| emu_req | input | 1 | Debug-mode bus request, asynchronous |
| core_boundary | input | 1 | Core instruction-complete strobe |
| core_ext_pend | input | 1 | Core has an external access waiting |
| bus_grant | output | 1 | Normal bus grant |
| bus_grant_oe | output | 1 | Output enable of the normal grant pin |
| emu_grant | output | 1 | Debug-mode bus grant |
| grant_hang | output | 1 | Core blocked on a loaned bus |
| drv_en | output | 1 | Core bus driver enable |
| core_stall | output | 1 | Stall to the core |

## Verification
The bench runs directed cases before the random run:
- The request-to-grant and release latencies are counted edge by edge. This separates a correct synchronizer depth from one that is too short or too long.
- A request is held with the boundary strobe low. This tells a grant gated on the boundary apart from one that skips it.
- A pending access is raised, then withdrawn, during a loan. This shows whether the hang flag follows the access or sticks.
- A request is raised during reset with no boundary strobe. This exposes a block that freezes the handshake in reset.
- Debug mode is run with normal-side inputs that conflict with it. This shows whether the request, reset and grant sets are swapped or mixed.

A biased random phase then toggles the request, boundary, pending access and mode select against a cycle model.

// File: rtl/bus_loan_pkg.sv
package bus_loan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE          = 2'd0,
        ST_WAIT_BOUNDARY = 2'd1,
        ST_GRANTED       = 2'd2,
        ST_GRANTED_HANG  = 2'd3
    } loan_state_t;

    function automatic logic is_loaned(loan_state_t s);
        return (s == ST_GRANTED) || (s == ST_GRANTED_HANG);
    endfunction

endpackage

// File: rtl/bus_loan_sync.sv
module bus_loan_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) chain[0] <= d_async;
            end else begin : g_next
                always_ff @(posedge clk) chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/bus_loan_sel.sv
module bus_loan_sel (
    input  logic emu_en,
    input  logic sys_rst,
    input  logic emu_rst,
    input  logic ext_req,
    input  logic emu_req,
    input  logic loaned,
    output logic sel_rst,
    output logic sel_req,
    output logic bus_grant,
    output logic bus_grant_oe,
    output logic emu_grant
);
    always_comb begin
        sel_rst      = emu_en ? emu_rst : sys_rst;
        sel_req      = emu_en ? emu_req : ext_req;
        bus_grant    = loaned & ~emu_en;
        emu_grant    = loaned & emu_en;
        bus_grant_oe = ~emu_en;
    end

    always_comb begin
        assert_grant_split_R8: assert (!(bus_grant && emu_grant));
    end
endmodule

// File: rtl/bus_loan_fsm.sv
module bus_loan_fsm
    import bus_loan_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_s,
    input  logic boundary,
    input  logic pend,
    output logic loaned,
    output logic hang,
    output logic drv_en,
    output logic stall
);
    loan_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        if (rst) begin
            state_nx = req_s ? ST_GRANTED : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:          if (req_s) state_nx = ST_WAIT_BOUNDARY;
                ST_WAIT_BOUNDARY: if (!req_s) state_nx = ST_IDLE;
                                  else if (boundary) state_nx = ST_GRANTED;
                ST_GRANTED:       if (!req_s) state_nx = ST_IDLE;
                                  else if (pend) state_nx = ST_GRANTED_HANG;
                ST_GRANTED_HANG:  if (!req_s) state_nx = ST_IDLE;
                                  else if (!pend) state_nx = ST_GRANTED;
                default:          state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) state <= state_nx;

    always_comb begin
        loaned = is_loaned(state);
        hang   = (state == ST_GRANTED_HANG);
        drv_en = ~loaned;
        stall  = pend & loaned;
    end

    assert_grant_at_boundary_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(loaned) |-> ($past(boundary) && $past(req_s)) || $past(rst));
    assert_release_on_drop_R4: assert property (@(posedge clk)
        !req_s |=> !loaned && !hang);
    assert_hang_needs_access_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(hang) |-> $past(pend));
    assert_hang_within_loan_R9: assert property (@(posedge clk) disable iff (rst)
        hang |-> loaned);
    assert_stall_only_loaned_R6: assert property (@(posedge clk) disable iff (rst)
        stall |-> loaned && pend);
endmodule

// File: rtl/bus_loan_ctrl.sv
module bus_loan_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic sys_rst,
    input  logic emu_rst,
    input  logic emu_en,
    input  logic ext_req,
    input  logic emu_req,
    input  logic core_boundary,
    input  logic core_ext_pend,
    output logic bus_grant,
    output logic bus_grant_oe,
    output logic emu_grant,
    output logic grant_hang,
    output logic drv_en,
    output logic core_stall
);
    logic sel_rst, sel_req, req_s, loaned;

    bus_loan_sel u_sel (
        .emu_en(emu_en), .sys_rst(sys_rst), .emu_rst(emu_rst),
        .ext_req(ext_req), .emu_req(emu_req), .loaned(loaned),
        .sel_rst(sel_rst), .sel_req(sel_req), .bus_grant(bus_grant),
        .bus_grant_oe(bus_grant_oe), .emu_grant(emu_grant)
    );

    bus_loan_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .d_async(sel_req), .q_sync(req_s)
    );

    bus_loan_fsm u_fsm (
        .clk(clk), .rst(sel_rst), .req_s(req_s), .boundary(core_boundary),
        .pend(core_ext_pend), .loaned(loaned), .hang(grant_hang),
        .drv_en(drv_en), .stall(core_stall)
    );

    assert_drivers_off_in_loan_R3: assert property (@(posedge clk) disable iff (sel_rst)
        (bus_grant || emu_grant) |-> !drv_en);
endmodule

// File: tb/bus_loan_ctrl_bench.sv
module bus_loan_ctrl_bench;
    logic clk = 0;
    logic sys_rst, emu_rst, emu_en, ext_req, emu_req, core_boundary, core_ext_pend;
    logic bus_grant, bus_grant_oe, emu_grant, grant_hang, drv_en, core_stall;
    int checks = 0, errors = 0;
    bit done = 0;
    logic m_s1 = 0, m_s2 = 0;
    int m_st = 0;

    always #2.5 clk = ~clk;

    bus_loan_ctrl u_bus_loan_ctrl (.*);

    function automatic int next_st(int st, logic rst, logic rq, logic bd, logic pd);
        if (rst) return rq ? 2 : 0;
        case (st)
            0: return rq ? 1 : 0;
            1: return !rq ? 0 : (bd ? 2 : 1);
            2: return !rq ? 0 : (pd ? 3 : 2);
            default: return !rq ? 0 : (pd ? 3 : 2);
        endcase
    endfunction

    task automatic chk(logic act, logic exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic g;
        g = (m_st >= 2);
        chk(bus_grant, g & ~emu_en, "R2");
        chk(emu_grant, g & emu_en, "R8");
        chk(bus_grant_oe, ~emu_en, "R8");
        chk(drv_en, ~g, "R3");
        chk(grant_hang, m_st == 3, "R5");
        chk(core_stall, core_ext_pend & g, "R6");
    endtask

    task automatic tick();
        @(posedge clk);
        m_st = next_st(m_st, emu_en ? emu_rst : sys_rst, m_s2, core_boundary, core_ext_pend);
        m_s2 = m_s1;
        m_s1 = emu_en ? emu_req : ext_req;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        sys_rst = 1; emu_rst = 0; emu_en = 0; ext_req = 0; emu_req = 0;
        core_boundary = 0; core_ext_pend = 0;
        @(negedge clk);
        repeat (4) tick();
        sys_rst = 0;
        tick();
        chk(bus_grant, 0, "R7"); chk(drv_en, 1, "R7"); chk(grant_hang, 0, "R7");

        // R1 latency with boundary held
        core_boundary = 1; ext_req = 1;
        repeat (3) tick();
        chk(bus_grant, 0, "R1");
        tick();
        chk(bus_grant, 1, "R1"); chk(drv_en, 0, "R3");

        // R5 / R9 hang follows pending access
        core_ext_pend = 1;
        tick();
        chk(grant_hang, 1, "R5"); chk(core_stall, 1, "R6");
        core_ext_pend = 0;
        tick();
        chk(grant_hang, 0, "R9"); chk(bus_grant, 1, "R9");
        core_ext_pend = 1;
        tick();
        chk(grant_hang, 1, "R5");

        // R4 release latency
        ext_req = 0;
        repeat (2) tick();
        chk(bus_grant, 1, "R4");
        tick();
        chk(bus_grant, 0, "R4"); chk(grant_hang, 0, "R4"); chk(drv_en, 1, "R4");
        chk(core_stall, 0, "R4");
        core_ext_pend = 0;

        // R2 no grant without boundary
        core_boundary = 0; ext_req = 1;
        repeat (8) tick();
        chk(bus_grant, 0, "R2");
        core_boundary = 1;
        tick();
        chk(bus_grant, 1, "R2");
        ext_req = 0; core_boundary = 0;
        repeat (4) tick();

        // R7 request honoured during reset, no boundary
        sys_rst = 1; ext_req = 1;
        repeat (2) tick();
        chk(bus_grant, 0, "R7");
        tick();
        chk(bus_grant, 1, "R7");
        ext_req = 0;
        repeat (3) tick();
        chk(bus_grant, 0, "R7");
        sys_rst = 0;
        repeat (2) tick();

        // R8 emulator set swaps in, normal side conflicting
        emu_en = 1; ext_req = 1; sys_rst = 0; emu_req = 0; core_boundary = 1;
        repeat (6) tick();
        chk(emu_grant, 0, "R8"); chk(bus_grant, 0, "R8"); chk(bus_grant_oe, 0, "R8");
        emu_req = 1;
        repeat (4) tick();
        chk(emu_grant, 1, "R8"); chk(bus_grant, 0, "R8");
        emu_rst = 1; sys_rst = 1; emu_req = 0;
        repeat (3) tick();
        chk(emu_grant, 0, "R8");
        emu_rst = 0; sys_rst = 0; emu_en = 0; ext_req = 0;
        repeat (4) tick();

        void'($urandom(32'd1357));
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 9) == 0) ext_req = ~ext_req;
            if ($urandom_range(0, 9) == 0) emu_req = ~emu_req;
            core_boundary = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 5) == 0) core_ext_pend = ~core_ext_pend;
            if ($urandom_range(0, 199) == 0) emu_en = ~emu_en;
            sys_rst = ($urandom_range(0, 99) == 0);
            emu_rst = ($urandom_range(0, 99) == 0);
            tick();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule